// File: doc/BRIEF.md
# DS1 Data Link Bit Inserter

This block sits in the transmit path of one DS1 framer channel. It places data link bits into the outgoing frame bit stream. The frame generator presents one frame bit per cycle, marked with `in_valid`. With each bit it supplies the active framing mode, the frame index inside the 24-frame superframe and the bit index inside the 193-bit frame. From these the block decides whether the current bit is a data link slot. In ESF mode the slots are the facility data link bits, in SLC96 mode the signaling framing bits, and in T1DM mode the remote signaling bits.

A 2-bit read/write select field chooses where slot bits come from: the HDLC controller stream, the serial transmit pin, the overhead input pin, or a constant one. In each slot cycle the block sends a one-cycle request to the selected source only. It takes that source's bit in the same cycle and puts it in the outbound stream. Every other bit passes through unchanged. A new select value waits for the next superframe boundary before it governs any slot.

Top module: `dl_link_insert`

## Requirements
- R1: With active select code 00, each slot bit is taken from `hdlc_bit` and `hdlc_req` pulses in that slot cycle.
- R2: With active select code 01, each slot bit is taken from `ser_bit` and `ser_req` pulses in that slot cycle.
- R3: With active select code 10, each slot bit is taken from `oh_bit` and `oh_req` pulses in that slot cycle.
- R4: With active select code 11, each slot bit is forced to 1 and no request is raised.
- R5: Mode 00 (ESF): a slot is bit index 0 of a frame with an even frame index (0, 2, ... 22), which are frames 1, 3, ... 23 counted from one. That gives 12 slots per superframe.
- R6: Mode 01 (SLC96): a slot is bit index 0 of a frame with an odd frame index.
- R7: Mode 10 (T1DM): a slot is bit index 192 (the last bit of the frame) of every frame.
- R8: A valid bit that is not a slot appears unchanged on `out_bit` one cycle later. `out_valid` repeats `in_valid` one cycle later.
- R9: At most one request is high in any cycle. A request is high only when `in_valid` is high and the current bit is a slot.
- R10: `cfg_rdata` returns the last value written through `cfg_we`/`cfg_wdata` in the cycle after the write. The field, the active selection and both outputs reset to 0.
- R11: A written select code becomes active at the next superframe boundary, which is a valid bit with frame index 0 and bit index 0. The boundary bit itself already uses the new code. Slots before the boundary keep the old code.
- R12: Mode 11 has no slots. All bits pass through and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the select field |
| cfg_wdata | input | 2 | Select code to write |
| cfg_rdata | output | 2 | Programmed select code |
| frm_mode | input | 2 | Framing mode: 00 ESF, 01 SLC96, 10 T1DM, 11 none |
| frm_idx | input | FW (5) | Frame index in superframe, 0 to FRAMES_PER_SF-1 |
| bit_idx | input | BW (8) | Bit index in frame, 0 to BITS_PER_FRAME-1 |
| in_valid | input | 1 | Frame bit present this cycle |
| in_bit | input | 1 | Frame bit from the frame generator |
| hdlc_bit | input | 1 | Data link bit from the HDLC controller |
| hdlc_req | output | 1 | Request strobe to the HDLC controller |
| ser_bit | input | 1 | Data link bit from the serial transmit pin |
| ser_req | output | 1 | Request strobe to the serial input |
| oh_bit | input | 1 | Data link bit from the overhead input pin |
| oh_req | output | 1 | Request strobe to the overhead input |
| out_valid | output | 1 | Output bit present |
| out_bit | output | 1 | Outbound frame bit |

## Verification
The hardest case to reach is a select change that lands between two slots of one superframe. The old code must keep serving the remaining slots, and the new code must take over exactly on the frame-0, bit-0 boundary bit. A directed sequence writes a new code in mid-superframe and then drives an ESF slot before the boundary. It then drives the boundary bit and checks which request fires and which source bit appears. Random traffic then jumps freely between frame and bit indices, modes and codes. A bench model that tracks the pending and active codes checks every cycle.

// File: rtl/dl_ins_pkg.sv
package dl_ins_pkg;
   typedef enum logic [1:0] {
      SRC_HDLC = 2'b00,
      SRC_SER  = 2'b01,
      SRC_OH   = 2'b10,
      SRC_ONE  = 2'b11
   } dl_src_e;

   typedef enum logic [1:0] {
      FM_ESF   = 2'b00,
      FM_SLC   = 2'b01,
      FM_T1DM  = 2'b10,
      FM_NONE  = 2'b11
   } frm_mode_e;

   localparam int NUM_REQ_SRC = 3;
endpackage

// File: rtl/dl_slot_decode.sv
module dl_slot_decode
   import dl_ins_pkg::*;
#(
   parameter int FRAMES_PER_SF  = 24,
   parameter int BITS_PER_FRAME = 193,
   localparam int FW = $clog2(FRAMES_PER_SF),
   localparam int BW = $clog2(BITS_PER_FRAME)
) (
   input  logic [1:0]    mode,
   input  logic [FW-1:0] frm_idx,
   input  logic [BW-1:0] bit_idx,
   output logic          slot,
   output logic          sf_start
);
   localparam logic [BW-1:0] RBIT_POS = BW'(BITS_PER_FRAME - 1);

   logic fbit;
   assign fbit     = (bit_idx == '0);
   assign sf_start = fbit && (frm_idx == '0);

   always_comb begin
      unique case (mode)
         FM_ESF:  slot = fbit && !frm_idx[0];
         FM_SLC:  slot = fbit &&  frm_idx[0];
         FM_T1DM: slot = (bit_idx == RBIT_POS);
         default: slot = 1'b0;
      endcase
   end
endmodule

// File: rtl/dl_src_select.sv
module dl_src_select
   import dl_ins_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_we,
   input  logic [1:0] cfg_wdata,
   output logic [1:0] cfg_rdata,
   input  logic       step,
   input  logic       sf_start,
   input  logic       slot,
   input  logic       hdlc_bit,
   input  logic       ser_bit,
   input  logic       oh_bit,
   output logic       hdlc_req,
   output logic       ser_req,
   output logic       oh_req,
   output logic       src_bit,
   output logic [1:0] eff_sel,
   output logic [1:0] act_sel
);
   logic [1:0] cfg_q, act_q;
   logic       fire;
   logic [NUM_REQ_SRC-1:0] req_vec;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= SRC_HDLC;
         act_q <= SRC_HDLC;
      end else begin
         if (cfg_we) cfg_q <= cfg_wdata;
         act_q <= eff_sel;
      end
   end

   assign eff_sel   = (step && sf_start) ? cfg_q : act_q;
   assign act_sel   = act_q;
   assign cfg_rdata = cfg_q;
   assign fire      = step && slot;

   for (genvar g = 0; g < NUM_REQ_SRC; g++) begin : g_req
      assign req_vec[g] = fire && (eff_sel == 2'(g));
   end

   assign hdlc_req = req_vec[int'(SRC_HDLC)];
   assign ser_req  = req_vec[int'(SRC_SER)];
   assign oh_req   = req_vec[int'(SRC_OH)];

   always_comb begin
      unique case (eff_sel)
         SRC_HDLC: src_bit = hdlc_bit;
         SRC_SER:  src_bit = ser_bit;
         SRC_OH:   src_bit = oh_bit;
         default:  src_bit = 1'b1;
      endcase
   end
endmodule

// File: rtl/dl_link_insert.sv
module dl_link_insert
   import dl_ins_pkg::*;
#(
   parameter int FRAMES_PER_SF  = 24,
   parameter int BITS_PER_FRAME = 193,
   parameter bit REG_OUT        = 1'b1,
   localparam int FW = $clog2(FRAMES_PER_SF),
   localparam int BW = $clog2(BITS_PER_FRAME)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [1:0]    cfg_wdata,
   output logic [1:0]    cfg_rdata,
   input  logic [1:0]    frm_mode,
   input  logic [FW-1:0] frm_idx,
   input  logic [BW-1:0] bit_idx,
   input  logic          in_valid,
   input  logic          in_bit,
   input  logic          hdlc_bit,
   output logic          hdlc_req,
   input  logic          ser_bit,
   output logic          ser_req,
   input  logic          oh_bit,
   output logic          oh_req,
   output logic          out_valid,
   output logic          out_bit
);
   if (FRAMES_PER_SF < 2 || (FRAMES_PER_SF % 2) != 0) begin : g_bad_frames
      $error("FRAMES_PER_SF must be even and at least 2");
   end
   if (BITS_PER_FRAME < 9) begin : g_bad_bits
      $error("BITS_PER_FRAME must hold a framing bit and a timeslot");
   end

   logic       slot_hit, sf_start, sf_hit, src_bit, merged;
   logic [1:0] eff_sel, act_sel;

   dl_slot_decode #(
      .FRAMES_PER_SF (FRAMES_PER_SF),
      .BITS_PER_FRAME(BITS_PER_FRAME)
   ) u_dec (
      .mode    (frm_mode),
      .frm_idx (frm_idx),
      .bit_idx (bit_idx),
      .slot    (slot_hit),
      .sf_start(sf_start)
   );

   dl_src_select u_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata),
      .step     (in_valid),
      .sf_start (sf_start),
      .slot     (slot_hit),
      .hdlc_bit (hdlc_bit),
      .ser_bit  (ser_bit),
      .oh_bit   (oh_bit),
      .hdlc_req (hdlc_req),
      .ser_req  (ser_req),
      .oh_req   (oh_req),
      .src_bit  (src_bit),
      .eff_sel  (eff_sel),
      .act_sel  (act_sel)
   );

   assign sf_hit = in_valid && sf_start;
   assign merged = (in_valid && slot_hit) ? src_bit : in_bit;

   if (REG_OUT) begin : g_reg_out
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            out_bit   <= 1'b0;
         end else begin
            out_valid <= in_valid;
            out_bit   <= merged;
         end
      end
   end else begin : g_comb_out
      assign out_valid = in_valid;
      assign out_bit   = merged;
   end
endmodule

// File: rtl/dl_link_insert_chk.sv
module dl_link_insert_chk #(
   parameter bit REG_OUT = 1'b1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       in_valid,
   input logic       in_bit,
   input logic       hdlc_req,
   input logic       ser_req,
   input logic       oh_req,
   input logic       out_valid,
   input logic       out_bit,
   input logic       slot_hit,
   input logic       sf_hit,
   input logic [1:0] eff_sel,
   input logic [1:0] act_sel
);
   // R9
   req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({hdlc_req, ser_req, oh_req}));

   // R9
   req_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hdlc_req || ser_req || oh_req) |-> (in_valid && slot_hit));

   // R11
   sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sf_hit |=> $stable(act_sel));

   if (REG_OUT) begin : g_seq
      // R4
      forced_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && slot_hit && eff_sel == 2'b11) |=> out_bit);

      // R8
      pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && !slot_hit) |=> (out_bit == $past(in_bit)));

      // R8
      valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);

      // R8
      idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid);
   end
endmodule

bind dl_link_insert dl_link_insert_chk #(.REG_OUT(REG_OUT)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_bit   (in_bit),
   .hdlc_req (hdlc_req),
   .ser_req  (ser_req),
   .oh_req   (oh_req),
   .out_valid(out_valid),
   .out_bit  (out_bit),
   .slot_hit (slot_hit),
   .sf_hit   (sf_hit),
   .eff_sel  (eff_sel),
   .act_sel  (act_sel)
);

// File: tb/tb_dl_link_insert.sv
module tb_dl_link_insert;
   localparam int FR = 24;
   localparam int BI = 193;
   localparam int FW = $clog2(FR);
   localparam int BW = $clog2(BI);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [1:0]    cfg_wdata = '0;
   logic [1:0]    cfg_rdata;
   logic [1:0]    frm_mode = '0;
   logic [FW-1:0] frm_idx = '0;
   logic [BW-1:0] bit_idx = '0;
   logic          in_valid = 1'b0, in_bit = 1'b0;
   logic          hdlc_bit = 1'b0, ser_bit = 1'b0, oh_bit = 1'b0;
   logic          hdlc_req, ser_req, oh_req, out_valid, out_bit;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [1:0] cfg_m = 2'b00;
   logic [1:0] act_m = 2'b00;
   logic [2:0] last_req;
   logic       last_out;

   always #2.5 clk = ~clk;

   dl_link_insert dut (.*);

   function automatic bit slot_of(input logic [1:0] m, input int f, input int b);
      case (m)
         2'b00:   return (b == 0) && (f % 2 == 0);
         2'b01:   return (b == 0) && (f % 2 == 1);
         2'b10:   return (b == BI - 1);
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic src_val(input logic [1:0] s, input logic h, input logic sr,
                                    input logic o);
      case (s)
         2'b00:   return h;
         2'b01:   return sr;
         2'b10:   return o;
         default: return 1'b1;
      endcase
   endfunction

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step(input logic v, input logic [1:0] m, input int f, input int b,
                       input logic ib, input logic h, input logic sr, input logic o,
                       input logic we, input logic [1:0] wd);
      logic [1:0] eff;
      logic       sl;
      logic [2:0] ereq;
      logic       eout;
      string      rtag, otag;
      @(negedge clk);
      in_valid = v; frm_mode = m; frm_idx = FW'(f); bit_idx = BW'(b);
      in_bit = ib; hdlc_bit = h; ser_bit = sr; oh_bit = o;
      cfg_we = we; cfg_wdata = wd;
      #1;
      eff  = (v && f == 0 && b == 0) ? cfg_m : act_m;
      sl   = v && slot_of(m, f, b);
      ereq = 3'b000;
      if (sl && eff != 2'b11) ereq[eff] = 1'b1;
      eout = sl ? src_val(eff, h, sr, o) : ib;
      if (!sl) rtag = (m == 2'b11) ? "R12" : "R9";
      else     rtag = (m == 2'b00) ? "R5" : (m == 2'b01) ? "R6" : "R7";
      case (eff)
         2'b00:   otag = "R1";
         2'b01:   otag = "R2";
         2'b10:   otag = "R3";
         default: otag = "R4";
      endcase
      if (!sl) otag = "R8";
      last_req = {oh_req, ser_req, hdlc_req};
      check(rtag, {5'd0, last_req}, {5'd0, ereq});
      @(posedge clk);
      #1;
      if (v && f == 0 && b == 0) act_m = cfg_m;
      if (we) cfg_m = wd;
      last_out = out_bit;
      check(otag, {7'd0, out_bit}, {7'd0, eout});
      check("R8", {7'd0, out_valid}, {7'd0, v});
      check("R10", {6'd0, cfg_rdata}, {6'd0, cfg_m});
   endtask

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      int seed_dummy;
      seed_dummy = $urandom(32'd20240611);
      repeat (3) @(posedge clk);
      #1;
      // R10 reset state
      check("R10", {6'd0, cfg_rdata}, 8'd0);
      check("R10", {7'd0, out_valid}, 8'd0);
      check("R10", {7'd0, out_bit}, 8'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // R5 ESF slot with HDLC source, bit 0 and 1
      step(1, 2'b00, 2, 0, 1'b0, 1'b1, 1'b0, 1'b0, 0, 2'b00);
      check("R1", {7'd0, last_out}, 8'd1);
      step(1, 2'b00, 3, 0, 1'b1, 1'b0, 1'b1, 1'b1, 0, 2'b00);
      check("R5", {5'd0, last_req}, 8'd0);
      // R11 write serial code mid-superframe; old code still serves slot
      step(0, 2'b00, 5, 7, 1'b0, 1'b0, 1'b0, 1'b0, 1, 2'b01);
      step(1, 2'b00, 22, 0, 1'b1, 1'b0, 1'b1, 1'b1, 0, 2'b00);
      check("R11", {5'd0, last_req}, 8'd1);
      check("R11", {7'd0, last_out}, 8'd0);
      // R11 boundary bit uses new code
      step(1, 2'b00, 0, 0, 1'b0, 1'b0, 1'b1, 1'b0, 0, 2'b00);
      check("R11", {5'd0, last_req}, 8'd2);
      check("R2", {7'd0, last_out}, 8'd1);
      // R3 overhead source via SLC96 slot
      step(0, 2'b01, 9, 9, 1'b0, 1'b0, 1'b0, 1'b0, 1, 2'b10);
      step(1, 2'b01, 0, 0, 1'b1, 1'b1, 1'b1, 1'b0, 0, 2'b00);
      step(1, 2'b01, 7, 0, 1'b0, 1'b0, 1'b0, 1'b1, 0, 2'b00);
      check("R6", {5'd0, last_req}, 8'd4);
      check("R3", {7'd0, last_out}, 8'd1);
      // R4 forced one via T1DM R-bit, no request
      step(0, 2'b10, 4, 4, 1'b0, 1'b0, 1'b0, 1'b0, 1, 2'b11);
      step(1, 2'b10, 0, 0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 2'b00);
      step(1, 2'b10, 13, BI - 1, 1'b0, 1'b0, 1'b0, 1'b0, 0, 2'b00);
      check("R4", {5'd0, last_req}, 8'd0);
      check("R7", {7'd0, last_out}, 8'd1);
      // R12 no slots in mode 11
      step(1, 2'b11, 0, 0, 1'b0, 1'b1, 1'b1, 1'b1, 0, 2'b00);
      check("R12", {7'd0, last_out}, 8'd0);
      // R9 invalid slot position raises nothing
      step(0, 2'b00, 2, 0, 1'b1, 1'b1, 1'b1, 1'b1, 0, 2'b00);
      check("R9", {5'd0, last_req}, 8'd0);

      for (int i = 0; i < 4000; i++) begin
         int r, b;
         r = int'($urandom % 4);
         b = (r == 0) ? 0 : (r == 1) ? BI - 1 : int'($urandom_range(0, BI - 1));
         step(($urandom % 8) != 0, 2'($urandom % 4), int'($urandom_range(0, FR - 1)), b,
              1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
              ($urandom % 12) == 0, 2'($urandom % 4));
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule